// File: doc/BRIEF.md
# Single-Wire Bus Master Timing Engine

This block produces the bit-level waveforms of a master on a single-wire open-drain bus with a pull-up resistor. For each command it plays out one slot: write a zero, write a one, read a bit, or a reset pulse followed by a presence watch. The line is pulled down through an active-low enable, `bus_pd_no`. The line level comes back on `bus_i` and passes through a two-flop synchronizer before any decision is made on it.

Every interval is counted in half-microsecond ticks. The tick comes from a clock divider whose ratio is the parameter `CLK_PER_HALF_US`. The divider restarts when a command is accepted, so each phase lasts an exact number of clocks. Two timing sets are available, regular and overdrive, and each command selects one of them. When a slot completes, the block gives a one-clock done strobe together with its results: the read bit, a presence code and a bus-error flag. The host above this block issues one command at a time and waits for the strobe before sending the next.

Top module: `owm_engine`

## Requirements
- R1: After reset `bus_pd_no` is 1, `busy_o` and `done_o` are 0, `bit_o` is 1, `pres_o` is 2'b01 (no device) and `bus_err_o` is 0.
- R2: Op code 2'b01 (write one) holds the line low for 6 us at regular speed (`cmd_od_i`=0) and for 1 us at overdrive (`cmd_od_i`=1).
- R3: Op code 2'b00 (write zero) holds the line low for 60 us at regular speed and for 7.5 us at overdrive.
- R4: Op code 2'b10 (read) holds the line low for 6 us at regular speed and 1 us at overdrive. `bit_o` then takes the synchronized line level sampled 13 us (regular) or 1.5 us (overdrive) after the slot starts. A device that holds the line low at that point gives `bit_o`=0.
- R5: Each of the three slot kinds keeps `busy_o` high for the slot plus a 2 us recovery with the line released: 72 us in total at regular speed and 12 us at overdrive.
- R6: Op code 2'b11 (reset) holds the line low for 480 us (regular) or 70 us (overdrive). It then releases the line and stays busy for a total of 960 us (regular) or 118 us (overdrive).
- R7: The line is sampled 70 us (regular) or 8.5 us (overdrive) after reset release. If it reads low, `pres_o` becomes 2'b00 (device present); if it reads high, `pres_o` becomes 2'b01 (no device).
- R8: If the line reads low 5 us (regular) or 1 us (overdrive) after reset release, `pres_o` becomes 2'b10 (bus error) and `bus_err_o` becomes 1, whatever the later sample shows. A reset without this fault clears `bus_err_o`.
- R9: A command that arrives while `busy_o` is high is ignored. The running slot keeps its timing and its results, and no second operation starts afterwards.
- R10: A command is accepted only while idle, and `busy_o` rises on the next clock. `done_o` is exactly one clock wide and arrives on the clock at which `busy_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command request, taken when idle |
| cmd_op_i | input | 2 | 00 write zero, 01 write one, 10 read, 11 reset/presence |
| cmd_od_i | input | 1 | 1 selects overdrive timing |
| bus_i | input | 1 | Raw line level (asynchronous) |
| bus_pd_no | output | 1 | Active-low pull-down enable for the line |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-clock completion strobe |
| bit_o | output | 1 | Bit from the last read slot |
| pres_o | output | 2 | Last presence result: 00 present, 01 none, 10 bus error |
| bus_err_o | output | 1 | Last reset saw the line low right after release |

## Verification
The bench runs every operation at both speeds. For each one it measures how many clocks the line is pulled low and how many clocks `busy_o` stays high. A design that confused the two timing sets, or that was off by one tick in the divider, would show up in those counts. A device model holds the line low after a read slot or answers a reset with a presence pulse. It can also short the line low for the whole operation: that must give the error code even though the later presence sample also reads low. A design that tested presence before the error window would report a present device there. A command injected halfway through a write-zero slot checks that a design which restarted or re-armed on a busy request would stretch the slot or start a stray operation.

// File: rtl/owm_pkg.sv
package owm_pkg;

  typedef enum logic [1:0] {
    OP_WR0   = 2'b00,
    OP_WR1   = 2'b01,
    OP_READ  = 2'b10,
    OP_RESET = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    PRES_YES  = 2'b00,
    PRES_NONE = 2'b01,
    PRES_ERR  = 2'b10
  } pres_e;

  // all values in half-microsecond ticks
  localparam int REG_SLOT    = 140;
  localparam int REG_REC     = 4;
  localparam int REG_W1_LOW  = 12;
  localparam int REG_W0_LOW  = 120;
  localparam int REG_RD_LOW  = 12;
  localparam int REG_RD_SAMP = 26;
  localparam int REG_RST_LOW = 960;
  localparam int REG_RST_HI  = 960;
  localparam int REG_ERR_CHK = 10;
  localparam int REG_PD_SAMP = 140;

  localparam int OD_SLOT     = 20;
  localparam int OD_REC      = 4;
  localparam int OD_W1_LOW   = 2;
  localparam int OD_W0_LOW   = 15;
  localparam int OD_RD_LOW   = 2;
  localparam int OD_RD_SAMP  = 3;
  localparam int OD_RST_LOW  = 140;
  localparam int OD_RST_HI   = 96;
  localparam int OD_ERR_CHK  = 2;
  localparam int OD_PD_SAMP  = 17;

  localparam int MAX_TICKS = REG_RST_LOW + REG_RST_HI;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  typedef struct packed {
    logic [CNT_W-1:0] low_end;
    logic [CNT_W-1:0] chk_at;
    logic [CNT_W-1:0] samp_at;
    logic [CNT_W-1:0] last;
  } plan_t;

  function automatic logic [CNT_W-1:0] tk(input int v);
    return CNT_W'(v);
  endfunction

  function automatic plan_t op_plan(input op_e op, input logic od);
    plan_t p;
    int slot_tot;
    slot_tot = od ? (OD_SLOT + OD_REC) : (REG_SLOT + REG_REC);
    p.chk_at  = '0;
    p.samp_at = '0;
    p.last    = tk(slot_tot - 1);
    case (op)
      OP_WR0:  p.low_end = od ? tk(OD_W0_LOW) : tk(REG_W0_LOW);
      OP_WR1:  p.low_end = od ? tk(OD_W1_LOW) : tk(REG_W1_LOW);
      OP_READ: begin
        p.low_end = od ? tk(OD_RD_LOW)  : tk(REG_RD_LOW);
        p.samp_at = od ? tk(OD_RD_SAMP) : tk(REG_RD_SAMP);
      end
      default: begin
        p.low_end = od ? tk(OD_RST_LOW) : tk(REG_RST_LOW);
        p.chk_at  = od ? tk(OD_RST_LOW + OD_ERR_CHK) : tk(REG_RST_LOW + REG_ERR_CHK);
        p.samp_at = od ? tk(OD_RST_LOW + OD_PD_SAMP) : tk(REG_RST_LOW + REG_PD_SAMP);
        p.last    = od ? tk(OD_RST_LOW + OD_RST_HI - 1) : tk(REG_RST_LOW + REG_RST_HI - 1);
      end
    endcase
    return p;
  endfunction

endpackage

// File: rtl/owm_tick.sv
module owm_tick #(
  parameter int DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] TOP = DW'(DIV - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            div_q <= '0;
    else if (clr_i)         div_q <= '0;
    else if (div_q == TOP)  div_q <= '0;
    else                    div_q <= div_q + 1'b1;
  end

  assign tick_o = (div_q == TOP);
endmodule

// File: rtl/owm_sync.sv
module owm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/owm_seq.sv
module owm_seq
  import owm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_i,
  input  op_e        op_i,
  input  logic       od_i,
  input  logic       line_i,
  output logic       busy_o,
  output logic       pull_o,
  output logic       done_o,
  output logic       bit_o,
  output logic [1:0] pres_o,
  output logic       err_o
);
  logic             busy_q, done_q, bit_q, err_q, chk_low_q, samp_low_q;
  logic [1:0]       pres_q;
  op_e              op_q;
  plan_t            plan_q;
  logic [CNT_W-1:0] cnt_q;
  logic             is_rst;

  assign is_rst = (op_q == OP_RESET);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      bit_q      <= 1'b1;
      err_q      <= 1'b0;
      pres_q     <= PRES_NONE;
      chk_low_q  <= 1'b0;
      samp_low_q <= 1'b0;
      op_q       <= OP_WR1;
      plan_q     <= '0;
      cnt_q      <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q     <= 1'b1;
          cnt_q      <= '0;
          op_q       <= op_i;
          plan_q     <= op_plan(op_i, od_i);
          chk_low_q  <= 1'b0;
          samp_low_q <= 1'b0;
        end
      end else if (tick_i) begin
        if (is_rst && cnt_q == plan_q.chk_at && !line_i) chk_low_q <= 1'b1;
        if (is_rst && cnt_q == plan_q.samp_at)           samp_low_q <= !line_i;
        if (op_q == OP_READ && cnt_q == plan_q.samp_at)  bit_q <= line_i;
        if (cnt_q == plan_q.last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          if (is_rst) begin
            err_q  <= chk_low_q;
            pres_q <= chk_low_q ? PRES_ERR : (samp_low_q ? PRES_YES : PRES_NONE);
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign pull_o = busy_q && (cnt_q < plan_q.low_end);
  assign done_o = done_q;
  assign bit_o  = bit_q;
  assign pres_o = pres_q;
  assign err_o  = err_q;
endmodule

// File: rtl/owm_engine.sv
module owm_engine
  import owm_pkg::*;
#(
  parameter int CLK_PER_HALF_US = 50,
  parameter int SYNC_STAGES     = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_op_i,
  input  logic       cmd_od_i,
  input  logic       bus_i,
  output logic       bus_pd_no,
  output logic       busy_o,
  output logic       done_o,
  output logic       bit_o,
  output logic [1:0] pres_o,
  output logic       bus_err_o
);
  logic accept, tick, line_s, pull;

  assign accept = cmd_valid_i && !busy_o;

  owm_tick #(.DIV(CLK_PER_HALF_US)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(accept), .tick_o(tick)
  );

  owm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(bus_i), .q_o(line_s)
  );

  owm_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .start_i(accept),
    .op_i(op_e'(cmd_op_i)), .od_i(cmd_od_i), .line_i(line_s),
    .busy_o(busy_o), .pull_o(pull), .done_o(done_o), .bit_o(bit_o),
    .pres_o(pres_o), .err_o(bus_err_o)
  );

  assign bus_pd_no = ~pull;
endmodule

// File: rtl/owm_engine_chk.sv
module owm_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic       bus_pd_no,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] pres_o,
  input logic       bus_err_o
);
  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_at_busy_fall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_accept_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o) |=> busy_o);

  assert_no_pull_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_pd_no |-> busy_o);

  assert_pull_release_before_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(bus_pd_no));

  assert_err_code_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> (pres_o == 2'b10));

  assert_pres_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pres_o != 2'b11);

  assert_results_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && $past(busy_o)) |-> $stable(bus_err_o));
endmodule

bind owm_engine owm_engine_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i),
  .bus_pd_no(bus_pd_no), .busy_o(busy_o), .done_o(done_o),
  .pres_o(pres_o), .bus_err_o(bus_err_o)
);

// File: tb/tb_owm_engine.sv
`timescale 1ns/1ps
module tb_owm_engine;
  localparam int DIV  = 2;
  localparam int CPUS = 2 * DIV;  // clocks per microsecond

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_od = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic bus, pd_n, busy, done, bitv, berr;
  logic [1:0] pres;

  always #2 clk = ~clk;

  // device model: 0 idle, 1 read-zero, 2 presence pulse, 3 shorted low
  int mode = 0;
  int rel  = 100000;
  logic dev_low;

  always @(posedge clk) begin
    if (!pd_n)            rel <= 0;
    else if (rel < 100000) rel <= rel + 1;
  end

  always_comb begin
    case (mode)
      1: dev_low = rel < (cmd_od ? 6 : 40);
      2: dev_low = cmd_od ? (rel >= 12 && rel < 52) : (rel >= 80 && rel < 480);
      3: dev_low = 1'b1;
      default: dev_low = 1'b0;
    endcase
  end
  assign bus = (!pd_n || dev_low) ? 1'b0 : 1'b1;

  owm_engine #(.CLK_PER_HALF_US(DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_od_i(cmd_od), .bus_i(bus), .bus_pd_no(pd_n), .busy_o(busy),
    .done_o(done), .bit_o(bitv), .pres_o(pres), .bus_err_o(berr)
  );

  int n_vec = 0, n_bad = 0;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  typedef struct {
    string tag;
    int    low_cyc;
    int    busy_cyc;
    bit    chk_bit;
    logic  bitv;
    bit    chk_pres;
    logic [1:0] pres;
    logic  err;
  } exp_t;

  exp_t exp_q[$];
  int low_c = 0, busy_c = 0;

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy)  busy_c++;
      if (!pd_n) low_c++;
      if (done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(low_c == e.low_cyc, {e.tag, " low"}, low_c, e.low_cyc);
          check(busy_c == e.busy_cyc, {e.tag, " busy R5/R6"}, busy_c, e.busy_cyc);
          if (e.chk_bit) check(bitv == e.bitv, {e.tag, " bit R4"}, int'(bitv), int'(e.bitv));
          if (e.chk_pres) begin
            check(pres == e.pres, {e.tag, " pres R7/R8"}, int'(pres), int'(e.pres));
            check(berr == e.err, {e.tag, " err R8"}, int'(berr), int'(e.err));
          end
        end
        low_c = 0;
        busy_c = 0;
      end
    end
  end

  // done must be one clock wide (R10)
  logic done_d = 1'b0;
  always @(negedge clk) begin
    if (rst_n && done && done_d) check(1'b0, "R10 done width", 2, 1);
    done_d <= done;
  end

  task automatic issue(input logic [1:0] op, input logic od, input exp_t e,
                       input bit inject_mid);
    exp_q.push_back(e);
    @(negedge clk);
    cmd_op = op; cmd_od = od; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy == 1'b1, {e.tag, " R10 busy rises"}, int'(busy), 1);
    if (inject_mid) begin
      repeat (50) @(negedge clk);
      cmd_op = 2'b11; cmd_od = 1'b1; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_od = od;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic exp_t slot(input string tag, input real low_us, input logic od);
    exp_t e;
    e.tag = tag;
    e.low_cyc = int'(low_us * CPUS);
    e.busy_cyc = od ? 12 * CPUS : 72 * CPUS;
    e.chk_bit = 0; e.bitv = 1'b1; e.chk_pres = 0; e.pres = 2'b01; e.err = 1'b0;
    return e;
  endfunction

  function automatic exp_t rd(input string tag, input logic od, input logic b);
    exp_t e;
    e = slot(tag, od ? 1.0 : 6.0, od);
    e.chk_bit = 1; e.bitv = b;
    return e;
  endfunction

  function automatic exp_t rst(input string tag, input logic od,
                               input logic [1:0] p, input logic er);
    exp_t e;
    e.tag = tag;
    e.low_cyc = od ? 70 * CPUS : 480 * CPUS;
    e.busy_cyc = od ? 118 * CPUS : 960 * CPUS;
    e.chk_bit = 0; e.bitv = 1'b1; e.chk_pres = 1; e.pres = p; e.err = er;
    return e;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(pd_n == 1'b1, "R1 pd", int'(pd_n), 1);
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(bitv == 1'b1, "R1 bit", int'(bitv), 1);
    check(pres == 2'b01, "R1 pres", int'(pres), 1);
    check(berr == 1'b0, "R1 err", int'(berr), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // regular speed
    issue(2'b01, 1'b0, slot("R2 wr1 reg", 6.0, 1'b0), 0);
    issue(2'b00, 1'b0, slot("R3 wr0 reg", 60.0, 1'b0), 0);
    issue(2'b10, 1'b0, rd("R4 rd1 reg", 1'b0, 1'b1), 0);
    mode = 1;
    issue(2'b10, 1'b0, rd("R4 rd0 reg", 1'b0, 1'b0), 0);
    mode = 0;
    issue(2'b11, 1'b0, rst("R6 R7 rst none reg", 1'b0, 2'b01, 1'b0), 0);
    mode = 2;
    issue(2'b11, 1'b0, rst("R7 rst pres reg", 1'b0, 2'b00, 1'b0), 0);
    mode = 3;
    issue(2'b11, 1'b0, rst("R8 rst short reg", 1'b0, 2'b10, 1'b1), 0);
    mode = 2;
    issue(2'b11, 1'b0, rst("R8 rst clears err", 1'b0, 2'b00, 1'b0), 0);
    mode = 0;

    // overdrive
    issue(2'b01, 1'b1, slot("R2 wr1 od", 1.0, 1'b1), 0);
    issue(2'b00, 1'b1, slot("R3 wr0 od", 7.5, 1'b1), 0);
    issue(2'b10, 1'b1, rd("R4 rd1 od", 1'b1, 1'b1), 0);
    mode = 1;
    issue(2'b10, 1'b1, rd("R4 rd0 od", 1'b1, 1'b0), 0);
    mode = 2;
    issue(2'b11, 1'b1, rst("R6 R7 rst pres od", 1'b1, 2'b00, 1'b0), 0);
    mode = 0;
    issue(2'b11, 1'b1, rst("R7 rst none od", 1'b1, 2'b01, 1'b0), 0);
    mode = 3;
    issue(2'b11, 1'b1, rst("R8 rst short od", 1'b1, 2'b10, 1'b1), 0);
    mode = 0;

    // command during a busy slot is ignored
    issue(2'b00, 1'b0, slot("R9 wr0 with busy cmd", 60.0, 1'b0), 1);
    repeat (20) @(negedge clk);
    check(busy == 1'b0, "R9 no stray op", int'(busy), 0);
    check(pd_n == 1'b1, "R9 line released", int'(pd_n), 1);
    check(exp_q.size() == 0, "R9 all results seen", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule